// File: doc/BRIEF.md
# Minimum-Cost Motion Vector Selector

This block sits at the tail of a full-search motion estimation pipeline that works on four macroblocks at once. Each clock cycle the upstream cost engines hand it one cost per macroblock: the count of non-matching points for the same candidate displacement. The block tracks, for each macroblock, the lowest cost seen so far and the displacement that produced it. At the end of the search it presents four motion vectors with their minimum costs and pulses a completion flag.

The candidates carry no coordinates. The block derives each displacement from the arrival order. The search window spans -16 to +16 pixels on both axes, which gives 33 x 33 = 1089 candidates. They are scanned one column at a time, starting from the leftmost column. Within a column the scan runs from the top row down. A search begins when the first candidate arrives with the start flag set, and that first candidate is always displacement (-16,-16).

Top module: `mvs_top`

## Requirements
- R1: A candidate accepted with `in_first` high is taken as displacement (-16,-16). It loads each lane's minimum cost and vector unconditionally, whatever those held before.
- R2: The candidate accepted at position i of a search (i = 0..1088) has horizontal component floor(i/33)-16 and vertical component (i mod 33)-16. Each component is output as a 6-bit two's-complement value.
- R3: A later candidate replaces a lane's stored result only when its cost is strictly lower. On equal cost the earlier candidate in scan order is kept.
- R4: The four lanes are independent. Lane k uses bits [k*9 +: 9] of `in_cost` and `best_cost`, and bits [k*6 +: 6] of `best_mv_x` and `best_mv_y`.
- R5: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts candidate 1089 (position 1088).
- R6: Once a search has completed, `in_valid` without `in_first` is ignored. The outputs hold their values and `done` stays low until the next `in_first`.
- R7: After reset, `done` and `busy` are 0, every `best_cost` lane reads 511, and every vector reads 0.
- R8: An `in_first` that arrives during a search restarts the scan at position 0. Results from the abandoned search do not carry over into the new one.
- R9: `busy` is high from the cycle after a start is accepted until the final candidate is accepted. It is low in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A candidate's four costs are present |
| in_first | input | 1 | This candidate starts a new search |
| in_cost | input | 36 | Four 9-bit costs, lane k at [k*9 +: 9] |
| best_mv_x | output | 24 | Four 6-bit horizontal components |
| best_mv_y | output | 24 | Four 6-bit vertical components |
| best_cost | output | 36 | Four 9-bit minimum costs |
| done | output | 1 | One-cycle search-complete pulse |
| busy | output | 1 | A search is in progress |

## Verification
The embedded properties check the following on every cycle:
- a start loads the incoming cost;
- an accepted candidate never raises a lane's stored cost;
- the stored result is frozen whenever nothing is accepted;
- the scan counters stay inside the window;
- `done` never lasts more than one cycle and never coincides with `busy`.

Whether the reported vector is the right one is shown only by the bench's scenarios: hashed costs, all-equal costs, a minimum at the end of the scan, and planted per-lane minima. Those scenarios also cover where the minimum falls in the scan, which candidate wins a tie, and a restart in mid-search.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
    localparam int unsigned MVS_RANGE  = 16;
    localparam int unsigned MVS_LANES  = 4;
    localparam int unsigned MVS_COST_W = 9;
endpackage

// File: rtl/mvs_scan.sv
module mvs_scan #(
    parameter int unsigned RANGE = 16,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned MV_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_first,
    output logic            accept,
    output logic            last_acc,
    output logic [MV_W-1:0] cur_x,
    output logic [MV_W-1:0] cur_y,
    output logic            busy
);
    localparam int unsigned SIDE = 2 * RANGE + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIDE - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] col;
        logic [IDX_W-1:0] row;
    } scan_t;

    scan_t s_d, s_q;
    logic [IDX_W-1:0] col_now, row_now;

    always_comb begin
        col_now  = in_first ? '0 : s_q.col;
        row_now  = in_first ? '0 : s_q.row;
        accept   = in_valid && (in_first || s_q.active);
        last_acc = accept && (col_now == LAST_IDX) && (row_now == LAST_IDX);
        cur_x    = MV_W'(col_now) - MV_W'(RANGE);
        cur_y    = MV_W'(row_now) - MV_W'(RANGE);
        busy     = s_q.active;
        s_d      = s_q;
        if (accept) begin
            s_d.active = 1'b1;
            s_d.col    = col_now;
            if (row_now == LAST_IDX) begin
                s_d.row = '0;
                if (col_now == LAST_IDX) begin
                    s_d.active = 1'b0;
                    s_d.col    = '0;
                end else begin
                    s_d.col = col_now + 1'b1;
                end
            end else begin
                s_d.row = row_now + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_ROW_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.row <= LAST_IDX && s_q.col <= LAST_IDX); // R2
    AST_FIRST_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |=> (s_q.active && s_q.row == IDX_W'(1) && s_q.col == '0)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !(in_valid && in_first)) |=> !s_q.active); // R6
endmodule

// File: rtl/mvs_hold.sv
module mvs_hold #(
    parameter int unsigned COST_W = 9,
    parameter int unsigned MV_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              first,
    input  logic [COST_W-1:0] cost,
    input  logic [MV_W-1:0]   mv_x,
    input  logic [MV_W-1:0]   mv_y,
    output logic [COST_W-1:0] best_cost,
    output logic [MV_W-1:0]   best_x,
    output logic [MV_W-1:0]   best_y
);
    typedef struct packed {
        logic [COST_W-1:0] cost;
        logic [MV_W-1:0]   x;
        logic [MV_W-1:0]   y;
    } best_t;

    best_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (accept && (first || cost < b_q.cost)) begin
            b_d.cost = cost;
            b_d.x    = mv_x;
            b_d.y    = mv_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '{cost: '1, x: '0, y: '0};
        else        b_q <= b_d;
    end

    assign best_cost = b_q.cost;
    assign best_x    = b_q.x;
    assign best_y    = b_q.y;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && first) |=> (best_cost == $past(cost))); // R1
    AST_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !first) |=> (best_cost <= $past(best_cost))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(best_cost) && $stable(best_x) && $stable(best_y))); // R6
endmodule

// File: rtl/mvs_top.sv
module mvs_top
    import mvs_pkg::*;
#(
    parameter int unsigned RANGE  = MVS_RANGE,
    parameter int unsigned LANES  = MVS_LANES,
    parameter int unsigned COST_W = MVS_COST_W,
    parameter int unsigned MV_W   = $clog2(RANGE) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic [LANES*COST_W-1:0] in_cost,
    output logic [LANES*MV_W-1:0]   best_mv_x,
    output logic [LANES*MV_W-1:0]   best_mv_y,
    output logic [LANES*COST_W-1:0] best_cost,
    output logic                    done,
    output logic                    busy
);
    localparam int unsigned SIDE  = 2 * RANGE + 1;
    localparam int unsigned IDX_W = $clog2(SIDE);

    logic            accept, last_acc;
    logic [MV_W-1:0] cur_x, cur_y;
    logic            done_d, done_q;

    mvs_scan #(.RANGE(RANGE), .IDX_W(IDX_W), .MV_W(MV_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .accept(accept), .last_acc(last_acc), .cur_x(cur_x), .cur_y(cur_y),
        .busy(busy)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        mvs_hold #(.COST_W(COST_W), .MV_W(MV_W)) u_hold (
            .clk(clk), .rst_n(rst_n), .accept(accept), .first(in_first),
            .cost(in_cost[k*COST_W +: COST_W]), .mv_x(cur_x), .mv_y(cur_y),
            .best_cost(best_cost[k*COST_W +: COST_W]),
            .best_x(best_mv_x[k*MV_W +: MV_W]),
            .best_y(best_mv_y[k*MV_W +: MV_W])
        );
    end

    always_comb done_d = last_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign done = done_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

// File: tb/tb_mvs_top.sv
module tb_mvs_top;
    localparam int L = 4, CW = 9, MW = 6, N = 1089;

    logic clk = 0, rst_n = 0, in_valid = 0, in_first = 0;
    logic [L*CW-1:0] in_cost = '0;
    logic [L*MW-1:0] best_mv_x, best_mv_y;
    logic [L*CW-1:0] best_cost;
    logic done, busy;

    mvs_top dut (.*);

    always #2 clk = ~clk;

    typedef struct { int x[L]; int y[L]; int c[L]; } exp_t;
    exp_t q[$];
    exp_t last_exp;
    int errors = 0, checks = 0, cycles = 0;
    bit prev_done = 0;

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int cost_of(int mode, int i, int k, int seed);
        case (mode)
            0: return (i * 37 + k * 101 + seed * 13) % 257;
            1: return 100;
            2: return (N - 1 - i) / 5;
            default: return (i == (k * 271 + seed) % N) ? k : 50 + ((i * 7 + k) % 200);
        endcase
    endfunction

    task automatic compare(exp_t e, string req);
        for (int k = 0; k < L; k++) begin
            chk($signed(best_mv_x[k*MW +: MW]) == e.x[k], {req, " mv_x"}, $signed(best_mv_x[k*MW +: MW]), e.x[k]);
            chk($signed(best_mv_y[k*MW +: MW]) == e.y[k], {req, " mv_y"}, $signed(best_mv_y[k*MW +: MW]), e.y[k]);
            chk(int'(best_cost[k*CW +: CW]) == e.c[k], {req, " cost"}, int'(best_cost[k*CW +: CW]), e.c[k]);
        end
    endtask

    task automatic drive(bit first, int mode, int i, int seed);
        @(posedge clk); #1;
        in_valid = 1; in_first = first;
        for (int k = 0; k < L; k++) in_cost[k*CW +: CW] = CW'(cost_of(mode, i, k, seed));
    endtask

    // R1 R2 R3 R4 R8: driver computes the expected winner per lane
    task automatic run_search(int mode, int seed, int abort_at);
        exp_t e;
        for (int k = 0; k < L; k++) begin
            e.c[k] = 1 << 30;
            for (int i = 0; i < N; i++) begin
                int c = cost_of(mode, i, k, seed);
                if (c < e.c[k]) begin
                    e.c[k] = c; e.x[k] = i / 33 - 16; e.y[k] = i % 33 - 16;
                end
            end
        end
        for (int i = 0; i < abort_at; i++) drive(i == 0, 0, i, seed + 7);
        q.push_back(e);
        for (int i = 0; i < N; i++) begin
            drive(i == 0, mode, i, seed);
            if (i == 500) begin
                @(negedge clk);
                chk(busy == 1, "R9 busy mid-search", busy, 1);
            end
        end
        @(posedge clk); #1; in_valid = 0; in_first = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0, "R9 busy after done", busy, 0);
    endtask

    // monitor: pop and compare on done; R5 pulse width
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) chk(0, "R5 done width", 2, 1);
            if (done) begin
                chk(busy == 0, "R9 busy with done", busy, 0);
                if (q.size() == 0) chk(0, "R5 R6 unexpected done", 1, 0);
                else begin
                    last_exp = q.pop_front();
                    compare(last_exp, "R2 R3 R4");
                end
            end
            prev_done = done;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                chk(0, "watchdog", cycles, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        chk(done == 0, "R7 done", done, 0);
        chk(busy == 0, "R7 busy", busy, 0);
        for (int k = 0; k < L; k++) begin
            chk(int'(best_cost[k*CW +: CW]) == 511, "R7 cost", int'(best_cost[k*CW +: CW]), 511);
            chk(best_mv_x[k*MW +: MW] == 0 && best_mv_y[k*MW +: MW] == 0, "R7 mv", int'(best_mv_x[k*MW +: MW]), 0);
        end
        rst_n = 1;
        run_search(0, 1, 0);
        run_search(1, 0, 0);   // R3 ties: expect (-16,-16)
        run_search(2, 0, 0);   // R2 minimum near end of scan
        run_search(3, 5, 0);   // R4 planted per-lane minima
        // R6 idle stimulus ignored
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; in_valid = 1; in_first = 0; in_cost = '0;
        end
        @(posedge clk); #1; in_valid = 0;
        @(negedge clk);
        compare(last_exp, "R6 hold");
        chk(done == 0, "R6 no done", done, 0);
        run_search(3, 9, 400); // R8 restart mid-search
        run_search(0, 3, 0);   // R1 fresh load over low previous minima
        repeat (3) @(posedge clk);
        chk(q.size() == 0, "R5 missing done", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule